// File: doc/BRIEF.md
# Gray-Coded Pointer Counter

This block keeps one side's pointer for a FIFO whose two sides run on unrelated clocks. The register holds only the Gray-coded form of the pointer. Each cycle, logic decodes the stored Gray word to binary and adds one when a step is requested and the side's blocking condition is clear. It then re-encodes the sum as Gray, and that word is the next register value. Because adjacent Gray words differ in one bit, the registered pointer can be passed straight into a two-stage synchronizer on the other side. The counter also exposes the decoded binary value and a memory address one bit narrower.

The pointer is one bit wider than the address. The extra top bit records how often the pointer has wrapped, and the comparison logic on the other side uses it to tell a full buffer from an empty one. A parameter selects the decoder structure: a serial XOR chain running down from the top bit, or an independent XOR reduction for each bit.

Top module: `gptr_counter`

## Requirements
- R1: While `rst_n` is low, `gray_ptr`, `bin_val` and `mem_addr` are all zero, and the reset takes effect without waiting for a clock edge.
- R2: At a rising edge where `inc_en` is 1 and `block_flag` is 0, `bin_val` becomes its previous value plus one, modulo 2^PTR_W. After the largest value it returns to zero.
- R3: At a rising edge where `inc_en` is 0, `gray_ptr` keeps its value.
- R4: At a rising edge where `block_flag` is 1, `gray_ptr` keeps its value even if `inc_en` is 1.
- R5: `gray_ptr` is the Gray encoding of `bin_val`. Bit PTR_W-1 equals the binary top bit, and every lower bit i equals `bin_val[i] ^ bin_val[i+1]`.
- R6: Any change of `gray_ptr` between consecutive cycles flips exactly one bit. This includes the wrap from the largest count, whose Gray word is 1 followed by zeros, back to zero.
- R7: `mem_addr` equals `bin_val[PTR_W-2:0]`, so it returns to zero every 2^(PTR_W-1) steps.
- R8: The low PTR_W-1 bits of `gray_ptr` are the (PTR_W-1)-bit Gray code of `mem_addr`, with bit PTR_W-2 additionally inverted whenever `bin_val[PTR_W-1]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of this FIFO side |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_en | input | 1 | Request to advance the pointer by one |
| block_flag | input | 1 | Full (write side) or empty (read side); blocks advancing |
| gray_ptr | output | PTR_W | Registered Gray pointer for the synchronizer |
| bin_val | output | PTR_W | Binary value decoded from the Gray register |
| mem_addr | output | PTR_W-1 | Storage address, low bits of the binary value |

## Verification
The hardest cases to reach are the two points in the sequence where the narrow address wraps but the wide pointer does not, and where the wide pointer returns to zero. Only at these points do R6 and R8 separate a correct encoder from one that mirrors the lower half. The stimulus therefore runs more than one full lap of 2^PTR_W steps, with holds and blocked requests mixed in just before and after the midpoint and the wrap. This checks that a blocked or idle cycle at those points leaves the pointer where it is. A reset in the middle of the run confirms that the register clears asynchronously and counting resumes from zero.

// File: rtl/gptr_pkg.sv
package gptr_pkg;

   // Structure used to decode the stored Gray word into binary
   typedef enum logic [0:0] {
      G2B_RIPPLE = 1'b0,   // serial chain from the top bit downward
      G2B_REDUCE = 1'b1    // per-bit XOR reduction, shallower logic
   } g2b_style_e;

   localparam int unsigned MIN_PTR_W = 2;
   localparam int unsigned MAX_PTR_W = 32;

endpackage

// File: rtl/gptr_g2b.sv
module gptr_g2b
   import gptr_pkg::*;
#(
   parameter int unsigned W     = 5,
   parameter g2b_style_e  STYLE = G2B_RIPPLE
) (
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);

   localparam int unsigned TOP = W - 1;

   generate
      if (STYLE == G2B_RIPPLE) begin : g_ripple
         // Each binary bit depends on the one decoded just above it
         assign bin_out[TOP] = gray_in[TOP];
         for (genvar i = 0; i < TOP; i++) begin : g_bit
            assign bin_out[i] = bin_out[i+1] ^ gray_in[i];
         end
      end else begin : g_reduce
         // Each binary bit is the parity of all Gray bits at or above it
         for (genvar i = 0; i < W; i++) begin : g_bit
            logic [W-1:0] upper;
            assign upper      = gray_in >> i;
            assign bin_out[i] = ^upper;
         end
      end
   endgenerate

endmodule

// File: rtl/gptr_b2g.sv
module gptr_b2g #(
   parameter int unsigned W = 5
) (
   input  logic [W-1:0] bin_in,
   output logic [W-1:0] gray_out
);

   localparam int unsigned TOP = W - 1;

   assign gray_out[TOP] = bin_in[TOP];
   generate
      for (genvar i = 0; i < TOP; i++) begin : g_bit
         assign gray_out[i] = bin_in[i] ^ bin_in[i+1];
      end
   endgenerate

endmodule

// File: rtl/gptr_step.sv
module gptr_step #(
   parameter int unsigned W = 5
) (
   input  logic [W-1:0] cur_bin,
   input  logic         advance,
   output logic [W-1:0] nxt_bin
);

   localparam logic [W-1:0] ONE = W'(1);

   always_comb begin
      nxt_bin = cur_bin;
      if (advance) begin
         nxt_bin = cur_bin + ONE;
      end
   end

endmodule

// File: rtl/gptr_counter.sv
module gptr_counter
   import gptr_pkg::*;
#(
   parameter int unsigned PTR_W     = 5,
   parameter g2b_style_e  G2B_STYLE = G2B_RIPPLE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_en,
   input  logic             block_flag,
   output logic [PTR_W-1:0] gray_ptr,
   output logic [PTR_W-1:0] bin_val,
   output logic [PTR_W-2:0] mem_addr
);

   localparam int unsigned ADDR_W = PTR_W - 1;

   generate
      if (PTR_W < MIN_PTR_W || PTR_W > MAX_PTR_W) begin : g_bad_width
         $error("gptr_counter: PTR_W out of supported range");
      end
   endgenerate

   logic [PTR_W-1:0] gray_q;
   logic [PTR_W-1:0] cur_bin;
   logic [PTR_W-1:0] nxt_bin;
   logic [PTR_W-1:0] nxt_gray;
   logic             step_ok;

   assign step_ok = inc_en & ~block_flag;

   gptr_g2b #(.W(PTR_W), .STYLE(G2B_STYLE)) u_dec (
      .gray_in (gray_q),
      .bin_out (cur_bin)
   );

   gptr_step #(.W(PTR_W)) u_step (
      .cur_bin (cur_bin),
      .advance (step_ok),
      .nxt_bin (nxt_bin)
   );

   gptr_b2g #(.W(PTR_W)) u_enc (
      .bin_in   (nxt_bin),
      .gray_out (nxt_gray)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gray_q <= '0;
      end else begin
         gray_q <= nxt_gray;
      end
   end

   assign gray_ptr = gray_q;
   assign bin_val  = cur_bin;
   assign mem_addr = cur_bin[ADDR_W-1:0];

endmodule

// File: rtl/gptr_counter_chk.sv
module gptr_counter_chk #(
   parameter int unsigned PTR_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             inc_en,
   input logic             block_flag,
   input logic [PTR_W-1:0] gray_ptr,
   input logic [PTR_W-1:0] bin_val,
   input logic [PTR_W-2:0] mem_addr
);

   localparam int unsigned ADDR_W = PTR_W - 1;

   // R2
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && !block_flag) |=> (bin_val == PTR_W'($past(bin_val) + 1'b1)));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inc_en |=> $stable(gray_ptr));

   // R4
   blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      block_flag |=> $stable(gray_ptr));

   // R5
   encode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gray_ptr == (bin_val ^ (bin_val >> 1)));

   // R6
   single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gray_ptr) |-> ($countones(gray_ptr ^ $past(gray_ptr)) == 1));

   // R7
   addr_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_addr == bin_val[ADDR_W-1:0]);

endmodule

bind gptr_counter gptr_counter_chk #(.PTR_W(PTR_W)) u_chk (.*);

// File: tb/gptr_counter_test.sv
`timescale 1ns/1ps
module gptr_counter_test;

   localparam int unsigned W  = 5;
   localparam int unsigned AW = W - 1;

   typedef struct {
      logic [W-1:0] bin;
      string        tag;
   } exp_item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          inc_en = 1'b0;
   logic          block_flag = 1'b0;
   logic [W-1:0]  gray_ptr;
   logic [W-1:0]  bin_val;
   logic [AW-1:0] mem_addr;

   int            n_checks = 0;
   int            n_fails = 0;
   logic [W-1:0]  model = '0;
   logic [W-1:0]  prev_gray = '0;
   logic          have_prev = 1'b0;
   exp_item_t     sb[$];

   always #2.5 clk = ~clk;   // 200 MHz

   gptr_counter #(.PTR_W(W)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc_en     (inc_en),
      .block_flag (block_flag),
      .gray_ptr   (gray_ptr),
      .bin_val    (bin_val),
      .mem_addr   (mem_addr)
   );

   function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   task automatic check(input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Driver: set inputs away from the edge, push the post-edge expectation
   task automatic drive(input logic inc, input logic blk, input string tag);
      @(negedge clk);
      inc_en     = inc;
      block_flag = blk;
      if (inc && !blk) model = model + 1'b1;
      sb.push_back('{bin: model, tag: tag});
      @(posedge clk);
   endtask

   // Monitor: compare just after each edge against the queued expectation
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_item_t it;
         logic [AW-1:0] low_exp;
         it = sb.pop_front();
         check({it.tag, " R2/R3/R4 bin_val"}, bin_val, it.bin);
         check("R5 gray_ptr", gray_ptr, to_gray(it.bin));
         check("R7 mem_addr", W'(mem_addr), W'(it.bin[AW-1:0]));
         low_exp = it.bin[AW-1:0] ^ (it.bin[AW-1:0] >> 1);
         low_exp[AW-1] = low_exp[AW-1] ^ it.bin[W-1];
         check("R8 gray low bits", W'(gray_ptr[AW-1:0]), W'(low_exp));
         if (have_prev && gray_ptr != prev_gray)
            check("R6 bits flipped", W'($countones(gray_ptr ^ prev_gray)), W'(1));
         prev_gray = gray_ptr;
         have_prev = 1'b1;
      end
   end

   initial begin
      fork
         begin
            #100us;
            n_fails++;
            $display("FAIL watchdog expired");
         end
         begin
            repeat (3) @(negedge clk);
            check("R1 reset gray", gray_ptr, '0);
            check("R1 reset bin", bin_val, '0);
            check("R1 reset addr", W'(mem_addr), '0);
            // Requests during reset must not move the pointer
            inc_en = 1'b1;
            @(negedge clk);
            check("R1 hold in reset", gray_ptr, '0);
            inc_en = 1'b0;
            rst_n  = 1'b1;
            @(posedge clk);
            // Straight run up to just before the midpoint
            for (int i = 0; i < 15; i++) drive(1'b1, 1'b0, "run");
            drive(1'b0, 1'b0, "R3 idle pre-mid");
            drive(1'b1, 1'b1, "R4 blocked pre-mid");
            drive(1'b1, 1'b0, "R8 midpoint");
            drive(1'b1, 1'b1, "R4 blocked at mid");
            drive(1'b0, 1'b1, "R3 idle blocked");
            // Mixed pattern up to the top
            for (int i = 0; i < 40; i++)
               drive(1'b1, (i % 3) == 2, "R2 mixed");
            // Bring to the wrap point and cross it
            while (model != {W{1'b1}}) drive(1'b1, 1'b0, "R2 approach");
            drive(1'b0, 1'b0, "R3 idle at top");
            drive(1'b1, 1'b1, "R4 blocked at top");
            drive(1'b1, 1'b0, "R6 wrap");
            for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, "R2 second lap");
            // Asynchronous reset in the middle of the run
            @(negedge clk);
            inc_en = 1'b0;
            #1 rst_n = 1'b0;
            #0.5;
            check("R1 async clear", gray_ptr, '0);
            check("R1 async clear bin", bin_val, '0);
            model = '0;
            have_prev = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            for (int i = 0; i < 6; i++) drive(1'b1, 1'b0, "R2 after reset");
            @(negedge clk);
            @(negedge clk);
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule